// File: doc/BRIEF.md
# Victim Buffer for an Exclusive Two-Level Cache

This block sits between a first-level cache and a second-level cache that never hold the same line at once. When the first level throws a line out, the line goes into this small, fully associative buffer instead of going straight down. That way the second-level read for the line being fetched can start in the same cycle, and the slow victim write stays out of the miss path.

The first level sends each of its misses here as a lookup. If the buffer holds the line, the line comes back one cycle later, its entry is freed, and no read goes to the second level. If the buffer does not hold it, the read request appears on the second-level read port in the same cycle, and a miss response follows one cycle later. An eviction whose address matches a lookup in the same cycle is handed straight back to that lookup and is never stored.

Once every entry is occupied, the buffer enters a drain phase. During this phase it refuses evictions and writes its oldest entries to the second level, one per accepted write. The phase ends when occupancy has fallen to a low-water mark.

Top module: `victim_buf`

## Requirements
- R1: After reset the buffer is empty. `evict_ready_o` is 1, and `rsp_valid_o`, `l2_wr_valid_o` and `l2_rd_valid_o` are 0.
- R2: A lookup whose address matches a stored entry gives `rsp_valid_o`=1, `rsp_hit_o`=1 and the stored line on `rsp_data_o` in the cycle after the lookup. No second-level read is issued in the lookup cycle.
- R3: The entry that a lookup hit is freed, so a later lookup of the same address misses.
- R4: A lookup that misses both the stored entries and a same-cycle eviction drives `l2_rd_valid_o`=1 with `l2_rd_addr_o` equal to the lookup address in that same cycle. The cycle after, it gives `rsp_valid_o`=1, `rsp_hit_o`=0 and a zero line.
- R5: An eviction accepted in the same cycle as a lookup of the same address returns the evicted line as a hit in the next cycle. No second-level read is issued, and the line is not stored.
- R6: An eviction and a lookup of a different address in the same cycle are both served in that cycle. The eviction is accepted, and the second-level read of the lookup address is issued.
- R7: `evict_ready_o` is 1 while fewer than DEPTH entries are occupied, and it falls to 0 as soon as all DEPTH entries are occupied.
- R8: While draining, the block offers its oldest entry on `l2_wr_addr_o`/`l2_wr_data_o` with `l2_wr_valid_o`=1 and removes it when `l2_wr_ready_i` is 1. It stops once occupancy has dropped to DRAIN_LOW (default DEPTH/2). At that point `l2_wr_valid_o` returns to 0 and `evict_ready_o` returns to 1. No eviction is accepted while it drains.
- R9: While `l2_wr_ready_i` is 0 and no lookup is presented, the offered drain entry stays the same.
- R10: A lookup that hits during a drain takes precedence. `l2_wr_valid_o` is 0 in that cycle, so no drain write completes.
- R11: Lines that have been drained are no longer held, so a lookup of them misses. Lines that were not drained still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Evicted line offered by the first level |
| evict_ready_o | output | 1 | Eviction can be taken this cycle |
| evict_addr_i | input | ADDR_W | Line address of the evicted line |
| evict_data_i | input | LINE_W | Evicted line contents |
| lk_valid_i | input | 1 | First-level miss lookup |
| lk_addr_i | input | ADDR_W | Line address looked up |
| rsp_valid_o | output | 1 | Lookup response, one cycle after the lookup |
| rsp_hit_o | output | 1 | Response carries a line from the buffer |
| rsp_data_o | output | LINE_W | Returned line, zero on a miss |
| l2_rd_valid_o | output | 1 | Read request toward the second level |
| l2_rd_addr_o | output | ADDR_W | Address of that read |
| l2_wr_valid_o | output | 1 | Drain write offered to the second level |
| l2_wr_ready_i | input | 1 | Second level accepts the drain write |
| l2_wr_addr_o | output | ADDR_W | Drain write line address |
| l2_wr_data_o | output | LINE_W | Drain write line contents |

## Verification
The lookup path is exercised with four patterns, and each one separates a different way a lookup can be resolved:
- a lookup of a stored line, then a second lookup of the same line, which tells a hit apart from a stale hit;
- a lookup with no matching line, which must go to the second-level read port;
- a lookup that coincides with an eviction of the same address, which tests forwarding;
- a lookup that coincides with an eviction of a different address, which shows the read and the victim acceptance overlapping.

The full-buffer case is driven three ways: with the second level stalled, with it accepting, and with a hit arriving mid-drain. These show whether drains leave oldest first, whether they hold under back-pressure, whether they stop at the low-water mark, and whether a hit pre-empts a write.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_RUN  = 1'b1
  } drain_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_i[g] && (tag_i[g] == addr_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/vb_store.sv
// Compacting entry array: index 0 holds the oldest line.
module vb_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rm_en_i,
  input  logic [IDX_W-1:0]             rm_idx_i,
  input  logic                         ins_en_i,
  input  logic [ADDR_W-1:0]            ins_addr_i,
  input  logic [LINE_W-1:0]            ins_data_i,
  output logic [DEPTH-1:0]             vld_o,
  output logic [DEPTH-1:0][ADDR_W-1:0] tag_o,
  output logic [DEPTH-1:0][LINE_W-1:0] data_o,
  output logic [CNT_W-1:0]             count_o
);
  logic [DEPTH-1:0]             vld_q, vld_n, up_vld;
  logic [DEPTH-1:0][ADDR_W-1:0] tag_q, tag_n, up_tag;
  logic [DEPTH-1:0][LINE_W-1:0] data_q, data_n, up_data;
  logic [CNT_W-1:0]             tail;

  for (genvar g = 0; g < DEPTH; g++) begin : g_up
    if (g < DEPTH - 1) begin : g_mid
      assign up_vld[g]  = vld_q[g+1];
      assign up_tag[g]  = tag_q[g+1];
      assign up_data[g] = data_q[g+1];
    end else begin : g_top
      assign up_vld[g]  = 1'b0;
      assign up_tag[g]  = tag_q[g];
      assign up_data[g] = data_q[g];
    end
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < DEPTH; i++) count_o = count_o + CNT_W'(vld_q[i]);
  end

  assign tail = count_o - CNT_W'(rm_en_i);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rm_en_i && (IDX_W'(i) >= rm_idx_i)) begin
        vld_n[i]  = up_vld[i];
        tag_n[i]  = up_tag[i];
        data_n[i] = up_data[i];
      end else begin
        vld_n[i]  = vld_q[i];
        tag_n[i]  = tag_q[i];
        data_n[i] = data_q[i];
      end
    end
    if (ins_en_i) begin
      vld_n[IDX_W'(tail)]  = 1'b1;
      tag_n[IDX_W'(tail)]  = ins_addr_i;
      data_n[IDX_W'(tail)] = ins_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_n;
  end

  always_ff @(posedge clk_i) begin
    tag_q  <= tag_n;
    data_q <= data_n;
  end

  assign vld_o  = vld_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;
endmodule

// File: rtl/vb_drain.sv
module vb_drain #(
  parameter int DEPTH     = 8,
  parameter int DRAIN_LOW = DEPTH / 2,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rm_en_i,
  output logic             active_o
);
  import vb_pkg::*;

  drain_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_after;

  assign cnt_after = count_i - CNT_W'(rm_en_i);
  // full forces the phase at once; it ends only at the low-water mark
  assign active_o  = (st_q == DR_RUN) || (count_i == CNT_W'(DEPTH));
  assign st_n      = (active_o && (cnt_after > CNT_W'(DRAIN_LOW))) ? DR_RUN : DR_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= DR_IDLE;
    else         st_q <= st_n;
  end
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 26,
  parameter int LINE_W    = 512,
  parameter int DRAIN_LOW = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  output logic              evict_ready_o,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [LINE_W-1:0] evict_data_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [LINE_W-1:0] rsp_data_o,
  output logic              l2_rd_valid_o,
  output logic [ADDR_W-1:0] l2_rd_addr_o,
  output logic              l2_wr_valid_o,
  input  logic              l2_wr_ready_i,
  output logic [ADDR_W-1:0] l2_wr_addr_o,
  output logic [LINE_W-1:0] l2_wr_data_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0][ADDR_W-1:0] tag;
  logic [DEPTH-1:0][LINE_W-1:0] data;
  logic [CNT_W-1:0]             count;
  logic                         tag_hit, buf_hit, fwd, evict_fire, pop;
  logic                         drain_active, rm_en, ins_en;
  logic [IDX_W-1:0]             hit_idx, rm_idx;
  logic                         rsp_valid_q, rsp_hit_q;
  logic [LINE_W-1:0]            rsp_data_q;

  vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .vld_i (vld),
    .tag_i (tag),
    .addr_i(lk_addr_i),
    .hit_o (tag_hit),
    .idx_o (hit_idx)
  );

  assign evict_ready_o = !drain_active;
  assign evict_fire    = evict_valid_i && evict_ready_o;
  assign buf_hit       = lk_valid_i && tag_hit;
  assign fwd           = lk_valid_i && evict_fire && !buf_hit && (evict_addr_i == lk_addr_i);

  // a buffer hit owns the single removal slot this cycle
  assign l2_wr_valid_o = drain_active && vld[0] && !buf_hit;
  assign l2_wr_addr_o  = tag[0];
  assign l2_wr_data_o  = data[0];
  assign pop           = l2_wr_valid_o && l2_wr_ready_i;

  assign rm_en  = buf_hit || pop;
  assign rm_idx = buf_hit ? hit_idx : '0;
  assign ins_en = evict_fire && !fwd;

  assign l2_rd_valid_o = lk_valid_i && !buf_hit && !fwd;
  assign l2_rd_addr_o  = lk_addr_i;

  vb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rm_en_i   (rm_en),
    .rm_idx_i  (rm_idx),
    .ins_en_i  (ins_en),
    .ins_addr_i(evict_addr_i),
    .ins_data_i(evict_data_i),
    .vld_o     (vld),
    .tag_o     (tag),
    .data_o    (data),
    .count_o   (count)
  );

  vb_drain #(.DEPTH(DEPTH), .DRAIN_LOW(DRAIN_LOW)) u_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count),
    .rm_en_i (rm_en),
    .active_o(drain_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= lk_valid_i;
      rsp_hit_q   <= buf_hit || fwd;
      rsp_data_q  <= buf_hit ? data[hit_idx] : (fwd ? evict_data_i : '0);
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evict_ready_o,
  input logic              lk_valid_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              l2_rd_valid_o,
  input logic              l2_wr_valid_o,
  input logic              l2_wr_ready_i,
  input logic [ADDR_W-1:0] l2_wr_addr_o
);
  a_r4_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);
  a_r4_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);
  a_r4_read_needs_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_rd_valid_o |-> lk_valid_i);
  a_r2_read_means_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_rd_valid_o |=> !rsp_hit_o);
  a_r8_no_evict_while_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_wr_valid_o |-> !evict_ready_o);
  a_r9_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_wr_valid_o && !l2_wr_ready_i && !lk_valid_i) |=> $stable(l2_wr_addr_o));
  a_r10_hit_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !l2_rd_valid_o) |-> !l2_wr_valid_o);
endmodule

bind victim_buf victim_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evict_ready_o(evict_ready_o),
  .lk_valid_i   (lk_valid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .l2_rd_valid_o(l2_rd_valid_o),
  .l2_wr_valid_o(l2_wr_valid_o),
  .l2_wr_ready_i(l2_wr_ready_i),
  .l2_wr_addr_o (l2_wr_addr_o)
);

// File: tb/victim_buf_bench.sv
module victim_buf_bench;
  localparam int ADDR_W = 26;
  localparam int LINE_W = 512;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ev_v = 1'b0, lk_v = 1'b0, wr_rdy = 1'b0;
  logic [ADDR_W-1:0] ev_a = '0, lk_a = '0;
  logic [LINE_W-1:0] ev_d = '0;
  logic              ev_rdy, rsp_v, rsp_h, rd_v, wr_v;
  logic [LINE_W-1:0] rsp_d, wr_d;
  logic [ADDR_W-1:0] rd_a, wr_a;
  int                n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  victim_buf u_victim_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .evict_valid_i(ev_v), .evict_ready_o(ev_rdy), .evict_addr_i(ev_a), .evict_data_i(ev_d),
    .lk_valid_i(lk_v), .lk_addr_i(lk_a),
    .rsp_valid_o(rsp_v), .rsp_hit_o(rsp_h), .rsp_data_o(rsp_d),
    .l2_rd_valid_o(rd_v), .l2_rd_addr_o(rd_a),
    .l2_wr_valid_o(wr_v), .l2_wr_ready_i(wr_rdy), .l2_wr_addr_o(wr_a), .l2_wr_data_o(wr_d)
  );

  function automatic logic [LINE_W-1:0] mk(input logic [ADDR_W-1:0] a);
    return {16{6'h2a, a}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one lookup, optional same-cycle evict; checks read port and response
  task automatic op(input bit do_ev, input logic [ADDR_W-1:0] ea,
                    input logic [ADDR_W-1:0] la, input bit exp_hit,
                    input logic [LINE_W-1:0] exp_d, input string req);
    @(negedge clk);
    ev_v = do_ev; ev_a = ea; ev_d = mk(ea);
    lk_v = 1'b1; lk_a = la;
    #1;
    chk(rd_v == !exp_hit, req, "l2 read valid", 64'(rd_v), 64'(!exp_hit));
    if (!exp_hit) chk(rd_a == la, req, "l2 read addr", 64'(rd_a), 64'(la));
    @(posedge clk);
    @(negedge clk);
    ev_v = 1'b0; lk_v = 1'b0;
    chk(rsp_v == 1'b1, req, "rsp valid", 64'(rsp_v), 64'd1);
    chk(rsp_h == exp_hit, req, "rsp hit", 64'(rsp_h), 64'(exp_hit));
    chk(rsp_d == exp_d, req, "rsp data", 64'(rsp_d[31:0]), 64'(exp_d[31:0]));
  endtask

  task automatic evict(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    ev_v = 1'b1; ev_a = a; ev_d = mk(a);
    #1;
    chk(ev_rdy == 1'b1, req, "evict ready", 64'(ev_rdy), 64'd1);
    @(posedge clk);
    @(negedge clk);
    ev_v = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(ev_rdy == 1'b1, "R1", "evict ready", 64'(ev_rdy), 64'd1);
    chk(rsp_v == 1'b0, "R1", "rsp valid", 64'(rsp_v), 64'd0);
    chk(wr_v == 1'b0, "R1", "wr valid", 64'(wr_v), 64'd0);
    chk(rd_v == 1'b0, "R1", "rd valid", 64'(rd_v), 64'd0);
  endtask

  task automatic t_hit_remove();
    evict(26'h100, "R2");
    evict(26'h101, "R2");
    op(1'b0, '0, 26'h100, 1'b1, mk(26'h100), "R2");
    op(1'b0, '0, 26'h100, 1'b0, '0, "R3");
    op(1'b0, '0, 26'h777, 1'b0, '0, "R4");
    op(1'b0, '0, 26'h101, 1'b1, mk(26'h101), "R2");
  endtask

  task automatic t_forward();
    op(1'b1, 26'h200, 26'h200, 1'b1, mk(26'h200), "R5");
    op(1'b0, '0, 26'h200, 1'b0, '0, "R5");
  endtask

  task automatic t_overlap();
    @(negedge clk);
    ev_v = 1'b1; ev_a = 26'h300; ev_d = mk(26'h300);
    lk_v = 1'b1; lk_a = 26'h301;
    #1;
    chk(ev_rdy == 1'b1, "R6", "evict ready", 64'(ev_rdy), 64'd1);
    chk(rd_v == 1'b1, "R6", "l2 read valid", 64'(rd_v), 64'd1);
    chk(rd_a == 26'h301, "R6", "l2 read addr", 64'(rd_a), 64'h301);
    @(posedge clk);
    @(negedge clk);
    ev_v = 1'b0; lk_v = 1'b0;
    chk(rsp_h == 1'b0, "R6", "rsp hit", 64'(rsp_h), 64'd0);
    op(1'b0, '0, 26'h300, 1'b1, mk(26'h300), "R6");
  endtask

  task automatic fill(input logic [ADDR_W-1:0] base);
    wr_rdy = 1'b0;
    for (int i = 0; i < DEPTH; i++) evict(base + ADDR_W'(i), "R7");
    chk(ev_rdy == 1'b0, "R7", "evict ready when full", 64'(ev_rdy), 64'd0);
  endtask

  task automatic t_drain();
    fill(26'h400);
    chk(wr_v == 1'b1, "R8", "wr valid", 64'(wr_v), 64'd1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(wr_a == 26'h400, "R9", "held wr addr", 64'(wr_a), 64'h400);
      chk(wr_d == mk(26'h400), "R9", "held wr data", 64'(wr_d[31:0]), 64'(mk(26'h400)));
    end
    for (int i = 0; i < DEPTH / 2; i++) begin
      @(negedge clk);
      wr_rdy = 1'b1;
      #1;
      chk(wr_v == 1'b1, "R8", "wr valid", 64'(wr_v), 64'd1);
      chk(wr_a == 26'h400 + ADDR_W'(i), "R8", "oldest first", 64'(wr_a), 64'(26'h400 + i));
      chk(ev_rdy == 1'b0, "R8", "evict stalled", 64'(ev_rdy), 64'd0);
      @(posedge clk);
    end
    @(negedge clk);
    wr_rdy = 1'b0;
    chk(wr_v == 1'b0, "R8", "drain stops", 64'(wr_v), 64'd0);
    chk(ev_rdy == 1'b1, "R8", "evict ready again", 64'(ev_rdy), 64'd1);
    op(1'b0, '0, 26'h400, 1'b0, '0, "R11");
    op(1'b0, '0, 26'h403, 1'b0, '0, "R11");
    for (int i = 4; i < DEPTH; i++)
      op(1'b0, '0, 26'h400 + ADDR_W'(i), 1'b1, mk(26'h400 + ADDR_W'(i)), "R11");
  endtask

  task automatic t_hit_in_drain();
    fill(26'h500);
    @(negedge clk);
    wr_rdy = 1'b1; lk_v = 1'b1; lk_a = 26'h505;
    #1;
    chk(wr_v == 1'b0, "R10", "wr blocked by hit", 64'(wr_v), 64'd0);
    chk(rd_v == 1'b0, "R10", "no l2 read", 64'(rd_v), 64'd0);
    @(posedge clk);
    @(negedge clk);
    lk_v = 1'b0;
    chk(rsp_h == 1'b1, "R10", "rsp hit", 64'(rsp_h), 64'd1);
    chk(rsp_d == mk(26'h505), "R10", "rsp data", 64'(rsp_d[31:0]), 64'(mk(26'h505)));
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(wr_v == 1'b1, "R10", "wr valid", 64'(wr_v), 64'd1);
      chk(wr_a == 26'h500 + ADDR_W'(i), "R10", "wr addr", 64'(wr_a), 64'(26'h500 + i));
      @(negedge clk);
    end
    wr_rdy = 1'b0;
    chk(wr_v == 1'b0, "R8", "drain stops at mark", 64'(wr_v), 64'd0);
    op(1'b0, '0, 26'h505, 1'b0, '0, "R3");
    op(1'b0, '0, 26'h503, 1'b1, mk(26'h503), "R11");
  endtask

  initial begin
    #200000;
    #(200000 * 10 - 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1'b1;
    t_reset();
    t_hit_remove();
    t_forward();
    t_overlap();
    t_drain();
    t_hit_in_drain();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule